// File: doc/BRIEF.md
# PHY Operating State Controller

This block sits on the PHY side of a MAC-to-PHY link and decides which operating state the PHY is in. The MAC drives two active-high strobes, one for transmit and one for receive, plus a sleep request. An active-low reset can arrive at any time, with no relation to the clock. The controller shows its current state as a three-bit power-management mode code. It raises a PHY-active flag while the PHY is sending or receiving. It also drives an enable for the PHY clock source, which is low while the PHY sleeps.

After reset is released, the controller runs a short internal start-up sequence and then settles in standby. From standby, the transmit strobe leads to transmit and the receive strobe leads to receive. A sleep request leads to sleep, where the clock enable drops. Outside sleep the strobes are clocked inputs. In sleep they are treated as asynchronous. A wake needs both strobes high together. That request passes through a two-flop synchronizer, turns the clock enable back on, and waits a fixed restart delay before standby is entered. The controller itself runs on an always-on clock, and `clk` must keep running while the PHY clock source is stopped.

Top module: `phy_state_ctrl`

## Requirements
- R1: While `rst_n` is low, from the first clock edge after it falls, `pm_mode` reads 0 (reset code), `phy_active` is 0 and `clk_run` is 1. `rst_n` must stay low for at least `PHY_RESET_TIME` clock edges.
- R2: After `rst_n` rises, the controller completes a start-up sequence of `INIT_CYCLES` cycles and then shows `pm_mode` = 1 (standby).
- R3: In standby, `tx_en` high leads to `pm_mode` = 2 (transmit). When `tx_en` falls, the controller returns to standby.
- R4: In standby with `tx_en` low, `rx_en` high leads to `pm_mode` = 3 (receive). When `rx_en` falls, the controller returns to standby.
- R5: If `tx_en` and `rx_en` are both high in standby, transmit wins.
- R6: `sleep_req` in standby leads to `pm_mode` = 4 (sleep) with `clk_run` low. `sleep_req` has no effect in transmit or receive, and sleep is entered only from standby.
- R7: In sleep, `tx_en` or `rx_en` alone has no effect. `pm_mode` stays 4 and `clk_run` stays 0.
- R8: In sleep, `tx_en` and `rx_en` high together are seen through a two-flop synchronizer, so `clk_run` rises no earlier than the third clock edge after they are set. `pm_mode` = 1 follows exactly `RESTART_CYCLES` cycles after `clk_run` rises, and sleep can be left only to standby.
- R9: `phy_active` is a register output that is 1 exactly when `pm_mode` is 2 or 3. `clk_run` is 0 only while `pm_mode` is 4.
- R10: A reset asserted in any state, including transmit, brings the controller back to the reset code and then, once released, to standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low reset, asynchronous to `clk` |
| tx_en | input | 1 | Transmit strobe from the MAC, active high |
| rx_en | input | 1 | Receive strobe from the MAC, active high |
| sleep_req | input | 1 | Request from the MAC to enter sleep |
| pm_mode | output | 3 | Power-management mode code: 0 reset, 1 standby, 2 transmit, 3 receive, 4 sleep |
| phy_active | output | 1 | High in transmit or receive |
| clk_run | output | 1 | Enable for the PHY clock source |

## Verification
The checker assumes that the MAC holds reset low for at least `PHY_RESET_TIME` edges. It also assumes that the strobes stay stable long enough to be seen, both by the state register outside sleep and by the synchronizer in sleep. The stimulus holds every reset for six or more cycles. It changes the strobes only on falling clock edges and keeps each level for several cycles. During a wake it drops both strobes once the clock enable returns. This keeps the restart delay from running into a transmit request, so each state is reached on purpose.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;

    typedef logic [2:0] pm_mode_t;

    localparam pm_mode_t PM_RESET   = 3'd0;
    localparam pm_mode_t PM_STANDBY = 3'd1;
    localparam pm_mode_t PM_TX      = 3'd2;
    localparam pm_mode_t PM_RX      = 3'd3;
    localparam pm_mode_t PM_SLEEP   = 3'd4;

    typedef enum logic [2:0] {
        ST_RESET   = 3'd0,
        ST_STANDBY = 3'd1,
        ST_TX      = 3'd2,
        ST_RX      = 3'd3,
        ST_SLEEP   = 3'd4,
        ST_WAKE    = 3'd5
    } phy_st_e;

    typedef struct packed {
        logic tx;
        logic rx;
    } en_pair_t;

    // The wake phase is still reported as sleep to the MAC.
    function automatic pm_mode_t mode_of(phy_st_e s);
        case (s)
            ST_STANDBY: return PM_STANDBY;
            ST_TX:      return PM_TX;
            ST_RX:      return PM_RX;
            ST_SLEEP:   return PM_SLEEP;
            ST_WAKE:    return PM_SLEEP;
            default:    return PM_RESET;
        endcase
    endfunction

    function automatic logic is_active(phy_st_e s);
        return (s == ST_TX) || (s == ST_RX);
    endfunction

endpackage

// File: rtl/phy_rst_sync.sv
// Reset asserts at once and releases on the clock.
module phy_rst_sync (
    input  logic clk,
    input  logic rst_n,
    output logic rst
);
    logic [1:0] stage;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= 2'b00;
        else        stage <= {stage[0], 1'b1};
    end

    assign rst = ~stage[1];
endmodule

// File: rtl/phy_sync2.sv
module phy_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/phy_state_fsm.sv
module phy_state_fsm
    import phy_ctrl_pkg::*;
#(
    parameter int INIT_CYCLES    = 4,
    parameter int RESTART_CYCLES = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  en_pair_t en_live,
    input  en_pair_t en_sync,
    input  logic     sleep_req,
    output pm_mode_t pm_mode,
    output logic     phy_active,
    output logic     clk_run
);
    localparam int CNT_MAX = (INIT_CYCLES > RESTART_CYCLES) ? INIT_CYCLES : RESTART_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] INIT_LAST    = CNT_W'(INIT_CYCLES - 1);
    localparam logic [CNT_W-1:0] RESTART_LAST = CNT_W'(RESTART_CYCLES - 1);

    phy_st_e          st, nxt;
    logic [CNT_W-1:0] cnt;
    logic             timed;

    always_comb begin
        nxt = st;
        case (st)
            ST_RESET:   if (cnt == INIT_LAST) nxt = ST_STANDBY;
            ST_STANDBY: begin
                if (en_live.tx)      nxt = ST_TX;
                else if (en_live.rx) nxt = ST_RX;
                else if (sleep_req)  nxt = ST_SLEEP;
            end
            ST_TX:      if (!en_live.tx) nxt = ST_STANDBY;
            ST_RX:      if (!en_live.rx) nxt = ST_STANDBY;
            ST_SLEEP:   if (en_sync.tx && en_sync.rx) nxt = ST_WAKE;
            ST_WAKE:    if (cnt == RESTART_LAST) nxt = ST_STANDBY;
            default:    nxt = ST_RESET;
        endcase
    end

    assign timed = (st == ST_RESET) || (st == ST_WAKE);

    // Outputs come from the next state so they switch cleanly on one edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_RESET;
            cnt        <= '0;
            pm_mode    <= PM_RESET;
            phy_active <= 1'b0;
            clk_run    <= 1'b1;
        end else begin
            st         <= nxt;
            cnt        <= (timed && nxt == st) ? cnt + 1'b1 : '0;
            pm_mode    <= mode_of(nxt);
            phy_active <= is_active(nxt);
            clk_run    <= (nxt != ST_SLEEP);
        end
    end
endmodule

// File: rtl/phy_state_ctrl.sv
module phy_state_ctrl
    import phy_ctrl_pkg::*;
#(
    parameter int PHY_RESET_TIME = 3,
    parameter int INIT_CYCLES    = 4,
    parameter int RESTART_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic       rx_en,
    input  logic       sleep_req,
    output logic [2:0] pm_mode,
    output logic       phy_active,
    output logic       clk_run
);
    logic     rst;
    en_pair_t en_live, en_sync;

    assign en_live = '{tx: tx_en, rx: rx_en};

    phy_rst_sync u_rst (
        .clk   (clk),
        .rst_n (rst_n),
        .rst   (rst)
    );

    phy_sync2 #(.W($bits(en_pair_t))) u_en_sync (
        .clk (clk),
        .rst (rst),
        .d   (en_live),
        .q   (en_sync)
    );

    phy_state_fsm #(
        .INIT_CYCLES    (INIT_CYCLES),
        .RESTART_CYCLES (RESTART_CYCLES)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .en_live    (en_live),
        .en_sync    (en_sync),
        .sleep_req  (sleep_req),
        .pm_mode    (pm_mode),
        .phy_active (phy_active),
        .clk_run    (clk_run)
    );
endmodule

// File: rtl/phy_state_chk.sv
module phy_state_chk #(
    parameter int PHY_RESET_TIME = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] pm_mode,
    input logic       phy_active,
    input logic       clk_run
);
    logic        rst_q;
    logic [15:0] low_cnt;

    always_ff @(posedge clk) begin
        rst_q <= rst_n;
        if (!rst_n) low_cnt <= (low_cnt == 16'hFFFF) ? low_cnt : low_cnt + 16'd1;
        else        low_cnt <= 16'd0;
    end

    // R1
    always_ff @(posedge clk) begin
        if (rst_n && rst_q === 1'b0)
            reset_hold_chk: assert (low_cnt >= 16'(PHY_RESET_TIME));
    end

    // R9
    active_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phy_active == (pm_mode == 3'd2 || pm_mode == 3'd3));

    // R9
    clk_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_run |-> pm_mode == 3'd4);

    // R6
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_mode == 3'd4 && $past(pm_mode) != 3'd4) |-> $past(pm_mode) == 3'd1);

    // R8
    sleep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pm_mode == 3'd4 |=> (pm_mode == 3'd4 || pm_mode == 3'd1));

    // R3
    tx_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pm_mode == 3'd2 |=> (pm_mode == 3'd2 || pm_mode == 3'd1));

    // R2
    legal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pm_mode <= 3'd4);
endmodule

bind phy_state_ctrl phy_state_chk #(.PHY_RESET_TIME(PHY_RESET_TIME)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pm_mode    (pm_mode),
    .phy_active (phy_active),
    .clk_run    (clk_run)
);

// File: tb/tb_phy_state_ctrl.sv
module tb_phy_state_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int INIT_C     = 4;
    localparam int RESTART_C  = 8;

    logic       clk = 1'b0;
    logic       rst_n, tx_en, rx_en, sleep_req;
    logic [2:0] pm_mode;
    logic       phy_active, clk_run;

    phy_state_ctrl #(
        .PHY_RESET_TIME (3),
        .INIT_CYCLES    (INIT_C),
        .RESTART_CYCLES (RESTART_C)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .rx_en      (rx_en),
        .sleep_req  (sleep_req),
        .pm_mode    (pm_mode),
        .phy_active (phy_active),
        .clk_run    (clk_run)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic [2:0] mode;
        string      req;
    } exp_t;

    exp_t       exp_q[$];
    int         total = 0;
    int         bad   = 0;
    logic       mon_en = 1'b0;
    logic [2:0] last_mode = 3'd0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_mode(input logic [2:0] m, input string req);
        exp_t e;
        e.mode = m;
        e.req  = req;
        exp_q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Scoreboard monitor: every mode change must match the next expected item.
    always @(negedge clk) begin
        if (mon_en && pm_mode !== last_mode) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected mode change", int'(pm_mode), int'(last_mode));
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(pm_mode === e.mode, e.req, int'(pm_mode), int'(e.mode));
            end
            last_mode = pm_mode;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        rst_n = 1'b0; tx_en = 1'b0; rx_en = 1'b0; sleep_req = 1'b0;
        step(10);
        chk(pm_mode === 3'd0, "R1 reset code", int'(pm_mode), 0);
        chk(phy_active === 1'b0, "R1 phy_active", int'(phy_active), 0);
        chk(clk_run === 1'b1, "R1 clk_run", int'(clk_run), 1);

        last_mode = 3'd0;
        mon_en    = 1'b1;
        expect_mode(3'd1, "R2 standby after init");
        rst_n = 1'b1;
        step(INIT_C + 4);
        chk(pm_mode === 3'd1, "R2 standby", int'(pm_mode), 1);

        expect_mode(3'd2, "R3 enter transmit");
        tx_en = 1'b1;
        step(3);
        chk(phy_active === 1'b1, "R9 active in transmit", int'(phy_active), 1);
        expect_mode(3'd1, "R3 leave transmit");
        tx_en = 1'b0;
        step(2);
        chk(phy_active === 1'b0, "R9 idle in standby", int'(phy_active), 0);

        expect_mode(3'd3, "R4 enter receive");
        rx_en = 1'b1;
        step(3);
        chk(phy_active === 1'b1, "R9 active in receive", int'(phy_active), 1);
        sleep_req = 1'b1;
        step(3);
        sleep_req = 1'b0;
        chk(pm_mode === 3'd3, "R6 sleep_req ignored in receive", int'(pm_mode), 3);
        expect_mode(3'd1, "R4 leave receive");
        rx_en = 1'b0;
        step(2);

        expect_mode(3'd2, "R5 transmit wins");
        tx_en = 1'b1; rx_en = 1'b1;
        step(3);
        chk(pm_mode === 3'd2, "R5 both enables", int'(pm_mode), 2);
        expect_mode(3'd1, "R5 back to standby");
        tx_en = 1'b0; rx_en = 1'b0;
        step(2);

        expect_mode(3'd4, "R6 enter sleep");
        sleep_req = 1'b1;
        step(1);
        sleep_req = 1'b0;
        step(2);
        chk(clk_run === 1'b0, "R6 clock stopped", int'(clk_run), 0);

        tx_en = 1'b1;
        step(6);
        chk(pm_mode === 3'd4, "R7 tx_en alone in sleep", int'(pm_mode), 4);
        chk(clk_run === 1'b0, "R7 clock still stopped", int'(clk_run), 0);
        tx_en = 1'b0; rx_en = 1'b1;
        step(6);
        chk(pm_mode === 3'd4, "R7 rx_en alone in sleep", int'(pm_mode), 4);
        rx_en = 1'b0;
        step(2);

        expect_mode(3'd1, "R8 wake to standby");
        tx_en = 1'b1; rx_en = 1'b1;
        n = 0;
        while (clk_run !== 1'b1 && n < 40) begin
            step(1);
            n++;
        end
        chk(clk_run === 1'b1, "R8 clock restarts", int'(clk_run), 1);
        chk(n >= 3, "R8 synchronizer latency", n, 3);
        tx_en = 1'b0; rx_en = 1'b0;
        n = 0;
        while (pm_mode !== 3'd1 && n < 60) begin
            step(1);
            n++;
        end
        chk(n == RESTART_C, "R8 restart delay", n, RESTART_C);

        expect_mode(3'd2, "R10 transmit before reset");
        tx_en = 1'b1;
        step(3);
        expect_mode(3'd0, "R10 reset from transmit");
        #2 rst_n = 1'b0;
        step(1);
        chk(pm_mode === 3'd0, "R10 reset code", int'(pm_mode), 0);
        chk(phy_active === 1'b0, "R10 phy_active cleared", int'(phy_active), 0);
        tx_en = 1'b0;
        step(5);
        expect_mode(3'd1, "R10 standby after reset");
        rst_n = 1'b1;
        step(INIT_C + 4);
        chk(pm_mode === 3'd1, "R10 standby", int'(pm_mode), 1);

        chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule